// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the purely combinational arithmetic/logic stage of a 32-bit integer datapath. Two operands and a 4-bit operation code enter; a result word, a zero flag, a signed-overflow flag and the raw carry leaving the top adder bit come out in the same cycle. Bitwise AND, OR, XOR and NOR come from a per-bit multiplexer. Add, subtract and both magnitude comparisons share one ripple adder. Subtraction flips every bit of the second operand and feeds a carry of 1 into bit 0.

An upstream decoder turns each instruction into the operation code below. Branch-on-equal logic subtracts and reads the zero flag. Trap logic uses the overflow flag, and that flag is only ever raised for the signed add and subtract codes. The carry output is there for test visibility; no flag is derived from it.

Top module: `int_alu`

## Requirements
- R1: Codes 0, 1, 2 and 3 give a bitwise opa AND opb, opa OR opb, opa XOR opb and NOT(opa OR opb) respectively, with ovf = 0.
- R2: Codes 4 (signed add) and 5 (unsigned add) give result = (opa + opb) mod 2^32.
- R3: Codes 6 (signed subtract) and 7 (unsigned subtract) give result = (opa - opb) mod 2^32.
- R4: For codes 4 and 6, ovf is 1 exactly when the signed result cannot be represented. This is the carry into bit 31 XOR the carry out of bit 31. It can only be raised when the effective operands (opb inverted for subtract) share a sign.
- R5: ovf is 0 for codes 5 and 7 and for every code other than 4 and 6.
- R6: Code 8 gives result = 1 when opa < opb as signed two's-complement numbers and 0 otherwise, with bits 31..1 zero. The answer is correct even when opa - opb overflows. ovf = 0.
- R7: Code 9 gives result = 1 when opa < opb as unsigned numbers and 0 otherwise, with bits 31..1 zero. ovf = 0.
- R8: zero is 1 exactly when all 32 result bits are 0, for every code.
- R9: carry_out is the carry leaving bit 31 of the adder for codes 4 through 9. For add codes this is that of opa + opb; for codes 6 through 9 it is that of opa + NOT opb + 1. For all other codes it is 0.
- R10: Codes 10 through 15 give result = 0, ovf = 0 and carry_out = 0, and therefore zero = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| alu_op | input | 4 | Operation code (see R1 to R10) |
| result | output | 32 | Operation result |
| zero | output | 1 | All result bits are zero |
| ovf | output | 1 | Signed overflow of codes 4 and 6 |
| carry_out | output | 1 | Carry leaving bit 31 of the adder |

## Verification
The block holds no state, so any fault in the internal control word or the carry chain shows at the ports in the same evaluation as the offending input. A wrong invert or carry-in control turns add into subtract or offsets results by one, which random add/subtract vectors expose immediately. Carry-chain or overflow faults appear only near the sign boundary, so directed vectors sit on the most positive and most negative values and on signed comparisons whose subtraction overflows.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_NOR  = 4'd3,
        OP_ADD  = 4'd4,
        OP_ADDU = 4'd5,
        OP_SUB  = 4'd6,
        OP_SUBU = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2,
        LF_NOR = 2'd3
    } logic_fn_e;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LOGIC = 2'd1,
        SEL_SUM   = 2'd2,
        SEL_LESS  = 2'd3
    } res_sel_e;

    typedef struct packed {
        res_sel_e  sel;
        logic_fn_e lfn;
        logic      invert_b;
        logic      ovf_en;
        logic      signed_cmp;
        logic      adder_used;
    } alu_ctrl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
    import int_alu_pkg::*;
(
    input  logic [OP_W-1:0] code,
    output alu_ctrl_t       ctrl
);
    always_comb begin
        ctrl = '{sel: SEL_NONE, lfn: LF_AND, invert_b: 1'b0,
                 ovf_en: 1'b0, signed_cmp: 1'b0, adder_used: 1'b0};
        unique case (code)
            OP_AND:  begin ctrl.sel = SEL_LOGIC; ctrl.lfn = LF_AND; end
            OP_OR:   begin ctrl.sel = SEL_LOGIC; ctrl.lfn = LF_OR;  end
            OP_XOR:  begin ctrl.sel = SEL_LOGIC; ctrl.lfn = LF_XOR; end
            OP_NOR:  begin ctrl.sel = SEL_LOGIC; ctrl.lfn = LF_NOR; end
            OP_ADD:  begin ctrl.sel = SEL_SUM; ctrl.ovf_en = 1'b1; ctrl.adder_used = 1'b1; end
            OP_ADDU: begin ctrl.sel = SEL_SUM; ctrl.adder_used = 1'b1; end
            OP_SUB:  begin ctrl.sel = SEL_SUM; ctrl.invert_b = 1'b1; ctrl.ovf_en = 1'b1;
                           ctrl.adder_used = 1'b1; end
            OP_SUBU: begin ctrl.sel = SEL_SUM; ctrl.invert_b = 1'b1; ctrl.adder_used = 1'b1; end
            OP_SLT:  begin ctrl.sel = SEL_LESS; ctrl.invert_b = 1'b1; ctrl.signed_cmp = 1'b1;
                           ctrl.adder_used = 1'b1; end
            OP_SLTU: begin ctrl.sel = SEL_LESS; ctrl.invert_b = 1'b1; ctrl.adder_used = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    output logic [W-1:0] sum,
    output logic         carry_msb_in,
    output logic         carry_msb_out
);
    always_comb begin
        logic c;
        logic bb;
        c = invert_b;
        carry_msb_in = 1'b0;
        sum = '0;
        for (int i = 0; i < W; i++) begin
            bb = b[i] ^ invert_b;
            sum[i] = a[i] ^ bb ^ c;
            if (i == W - 1) carry_msb_in = c;
            c = (a[i] & bb) | (a[i] & c) | (bb & c);
        end
        carry_msb_out = c;
    end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (fn)
                LF_AND:  y[i] = a[i] & b[i];
                LF_OR:   y[i] = a[i] | b[i];
                LF_XOR:  y[i] = a[i] ^ b[i];
                default: y[i] = ~(a[i] | b[i]);
            endcase
        end
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic [OP_W-1:0] alu_op,
    output logic [W-1:0]    result,
    output logic            zero,
    output logic            ovf,
    output logic            carry_out
);
    alu_ctrl_t    ctrl;
    logic [W-1:0] sum;
    logic [W-1:0] lres;
    logic         c_in_msb;
    logic         c_out_msb;
    logic         ovf_raw;
    logic         less;

    int_alu_decode u_dec (
        .code (alu_op),
        .ctrl (ctrl)
    );

    int_alu_adder #(.W(W)) u_add (
        .a             (opa),
        .b             (opb),
        .invert_b      (ctrl.invert_b),
        .sum           (sum),
        .carry_msb_in  (c_in_msb),
        .carry_msb_out (c_out_msb)
    );

    int_alu_logic #(.W(W)) u_log (
        .a  (opa),
        .b  (opb),
        .fn (ctrl.lfn),
        .y  (lres)
    );

    assign ovf_raw = c_in_msb ^ c_out_msb;
    // signed: sign of difference corrected by overflow; unsigned: borrow
    assign less = ctrl.signed_cmp ? (sum[W-1] ^ ovf_raw) : ~c_out_msb;

    always_comb begin
        unique case (ctrl.sel)
            SEL_LOGIC: result = lres;
            SEL_SUM:   result = sum;
            SEL_LESS:  result = {{(W-1){1'b0}}, less};
            default:   result = '0;
        endcase
    end

    assign zero      = ~|result;
    assign ovf       = ctrl.ovf_en & ovf_raw;
    assign carry_out = ctrl.adder_used & c_out_msb;
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic [W-1:0]    opa,
    input logic [W-1:0]    opb,
    input logic [OP_W-1:0] alu_op,
    input logic [W-1:0]    result,
    input logic            zero,
    input logic            ovf,
    input logic            carry_out
);
    always_comb begin
        p_zero_flag_r8: assert (zero == (result == '0))
            else $error("zero flag disagrees with result");
        p_no_overflow_r5: assert (!ovf || alu_op == OP_ADD || alu_op == OP_SUB)
            else $error("overflow on a non-signed code");
        p_ovf_add_sign_r4: assert (!(ovf && alu_op == OP_ADD) ||
                                   (opa[W-1] == opb[W-1] && result[W-1] != opa[W-1]))
            else $error("add overflow with mismatched signs");
        p_ovf_sub_sign_r4: assert (!(ovf && alu_op == OP_SUB) ||
                                   (opa[W-1] != opb[W-1] && result[W-1] != opa[W-1]))
            else $error("subtract overflow with matching signs");
        p_cmp_upper_r6: assert (!(alu_op == OP_SLT || alu_op == OP_SLTU) ||
                                result[W-1:1] == '0)
            else $error("compare result has upper bits set");
        p_unused_code_r10: assert (alu_op <= OP_SLTU ||
                                   (result == '0 && !ovf && !carry_out))
            else $error("unused code produced output");
        p_cout_quiet_r9: assert (!(alu_op <= OP_NOR) || !carry_out)
            else $error("carry out on a logic code");
    end
endmodule

bind int_alu int_alu_checker #(.W(W)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .alu_op    (alu_op),
    .result    (result),
    .zero      (zero),
    .ovf       (ovf),
    .carry_out (carry_out)
);

// File: tb/int_alu_test.sv
module int_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] opa, opb;
    logic [3:0]   alu_op;
    logic [W-1:0] result;
    logic         zero, ovf, carry_out;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    int_alu #(.W(W)) uut (
        .opa(opa), .opb(opb), .alu_op(alu_op),
        .result(result), .zero(zero), .ovf(ovf), .carry_out(carry_out)
    );

    function automatic logic [W:0] addw(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic sub);
        return sub ? ({1'b0, a} + {1'b0, ~b} + 1) : ({1'b0, a} + {1'b0, b});
    endfunction

    function automatic logic [W-1:0] exp_res(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [3:0] op);
        case (op)
            4'd0: return a & b;
            4'd1: return a | b;
            4'd2: return a ^ b;
            4'd3: return ~(a | b);
            4'd4, 4'd5: return a + b;
            4'd6, 4'd7: return a - b;
            4'd8: return {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            4'd9: return {{(W-1){1'b0}}, (a < b)};
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [W-1:0] a, input logic [W-1:0] b,
                                     input logic [3:0] op);
        logic [W-1:0] s;
        if (op == 4'd4) begin
            s = a + b;
            return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
        end
        if (op == 4'd6) begin
            s = a - b;
            return (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
        end
        return 1'b0;
    endfunction

    function automatic logic exp_cout(input logic [W-1:0] a, input logic [W-1:0] b,
                                      input logic [3:0] op);
        logic [W:0] t;
        if (op == 4'd4 || op == 4'd5) begin t = addw(a, b, 1'b0); return t[W]; end
        if (op >= 4'd6 && op <= 4'd9) begin t = addw(a, b, 1'b1); return t[W]; end
        return 1'b0;
    endfunction

    function automatic string res_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3: return "R1";
            4'd4, 4'd5: return "R2";
            4'd6, 4'd7: return "R3";
            4'd8: return "R6";
            4'd9: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag, alu_op, opa, opb, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] op);
        logic [W-1:0] er;
        @(negedge clk);
        opa = a; opb = b; alu_op = op;
        #1;
        er = exp_res(a, b, op);
        chk(res_tag(op), result, er);
        chk("R8", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (er == '0)});
        chk((op == 4'd4 || op == 4'd6) ? "R4" : "R5",
            {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, exp_ovf(a, b, op)});
        chk("R9", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, exp_cout(a, b, op)});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] maxp, minn;
        maxp = {1'b0, {(W-1){1'b1}}};
        minn = {1'b1, {(W-1){1'b0}}};
        opa = '0; opb = '0; alu_op = 4'd0;
        void'($urandom(32'd20250611));

        // initial state: all-zero inputs, AND code (R1, R8)
        apply('0, '0, 4'd0);

        // logic codes (R1)
        for (int k = 0; k < 4; k++) apply(32'hF0F0_A5A5, 32'h0FF0_5A0F, 4'(k));
        // signed overflow boundaries (R4) and unsigned forms (R5)
        apply(maxp, 32'd1, 4'd4);
        apply(maxp, 32'd1, 4'd5);
        apply(minn, minn, 4'd4);
        apply(minn, 32'd1, 4'd6);
        apply(minn, 32'd1, 4'd7);
        apply(maxp, 32'hFFFF_FFFF, 4'd6);
        apply(maxp, minn, 4'd4);
        // carry out (R9)
        apply(32'hFFFF_FFFF, 32'd1, 4'd5);
        apply(32'd5, 32'd5, 4'd7);
        // equality via subtract, zero flag (R3, R8)
        apply(32'h1234_5678, 32'h1234_5678, 4'd6);
        // signed compare with overflowing subtraction (R6)
        apply(minn, 32'd1, 4'd8);
        apply(maxp, 32'hFFFF_FFFF, 4'd8);
        apply(32'hFFFF_FFFF, 32'd0, 4'd8);
        apply(32'd3, 32'd3, 4'd8);
        // unsigned compare (R7)
        apply(32'd0, 32'hFFFF_FFFF, 4'd9);
        apply(32'hFFFF_FFFF, 32'd0, 4'd9);
        apply(32'd7, 32'd7, 4'd9);
        // unused codes (R10)
        for (int k = 10; k < 16; k++) apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(k));

        // constrained random: operands sometimes near the sign boundary
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if ((n % 5) == 0) ra = {ra[W-1], {(W-4){~ra[W-1]}}, ra[2:0]};
            if ((n % 7) == 0) rb = ra;
            apply(ra, rb, 4'($urandom_range(0, 15)));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule